// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Controller

This block generates the common and segment drive codes for a multiplexed segment LCD with up to 40 segment lines and 4 common lines, which gives 160 pixels at most. Software programs a mode register, with fields for the number of active commons, the bias scheme, the clock source and the post-divider, and a segment group enable register. It fills a display memory that holds one 4-bit word per segment line and then sets the enable bit. From that point the block runs without further help. It steps through the active commons in turn and reads the pixel bit of every segment for the common being driven. Each frame it reverses the drive polarity, so that every pixel sees zero average voltage.

Each pin carries a 2-bit level code from 0 to 3. The code stands for a fraction of the LCD supply, and an external resistor ladder or switch network turns it into a voltage. The scan timebase comes from one of two tick-enable inputs. The slow tick is divided by 32 and the fast tick by 8192. The result is then divided again by 1, 2, 4 or 8, and the scan step is a single-cycle enable pulse.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset, every common and segment output is code 0, both registers read 0, and every display word is 0.
- R2: Mode register (cfg_addr 0) fields: bits [1:0] commons code, bit 2 bias (0 = third, 1 = half), bit 3 enable, bits [5:4] post-divider exponent, bit 6 source (0 = slow/32, 1 = fast/8192). Bit 7 always reads 0. Group register (cfg_addr 1): bits [4:0] read back, bits [7:5] read 0.
- R3: While enable is 0, or while the commons code is 00, every output pin is code 0 and the scan is held at its start.
- R4: One common period lasts exactly SRC × 2^exp × TICKS_PER_COM ticks of the selected source (SRC = 32 slow, 8192 fast). Ticks of the other source have no effect, and the step happens on the clock edge that samples the last tick.
- R5: Commons code 01, 10 and 11 select 2, 3 and 4 active commons. The scan starts at COM0 on enable, steps upward, and returns to COM0 after the last active common.
- R6: The frame polarity is 0 for the first frame after enable and toggles each time the scan returns to COM0.
- R7: Common pins: the driven common outputs 3 in polarity 0 and 0 in polarity 1. Any other common, including any beyond the selected count, outputs 1/2 (polarity 0/1) in third bias and 2 in half bias.
- R8: Segment pins: a lit pixel outputs 0/3 (polarity 0/1). An unlit pixel outputs 2/1 in third bias and 3/0 in half bias.
- R9: The display word at address s (below 40) belongs to segment s, and bit n belongs to COMn. A write made during scanning shows on the outputs in the next cycle. Writes to addresses 40 and above change nothing.
- R10: Bit g of the group register enables segments 8g to 8g+7. A disabled group outputs code 0.
- R11: In half bias no pin ever outputs code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 mode, 1 group enables |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| slow_tick | input | 1 | Slow source tick enable |
| fast_tick | input | 1 | Fast source tick enable |
| ram_we | input | 1 | Display memory write strobe |
| ram_addr | input | 6 | Display memory word address (segment index) |
| ram_wdata | input | 4 | Display word, bit n for COMn |
| com_lvl | output | 8 | Level code of common n at bits [2n+1:2n] |
| seg_lvl | output | 80 | Level code of segment s at bits [2s+1:2s] |

## Verification
The bench checks every pin in every cycle against a model that counts source ticks. A timebase that is off by one tick, or that also counts the unselected source, therefore shifts a common step by a cycle and shows up at once. The cases it targets are: the wrap at each of the three common counts, which a wrong comparison would turn into a stuck or skipped common; the polarity toggle at the wrap; display writes made during the scan, including writes above the last segment, which a design that aliases addresses would let corrupt a live segment; and the invalid commons code 00 with enable set, which a careless design would scan as four commons.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef logic [1:0] lvl_t;

   localparam lvl_t LVL_GND = 2'd0;
   localparam lvl_t LVL_LO  = 2'd1;
   localparam lvl_t LVL_HI  = 2'd2;
   localparam lvl_t LVL_TOP = 2'd3;

   typedef struct packed {
      logic       src;    // bit 6
      logic [1:0] div;    // bits 5:4
      logic       en;     // bit 3
      logic       bias;   // bit 2, 1 = half bias
      logic [1:0] duty;   // bits 1:0
   } mode_t;

   // level on a common pin
   function automatic lvl_t com_level(input logic sel, input logic ph, input logic half);
      if (sel)  return ph ? LVL_GND : LVL_TOP;
      if (half) return LVL_HI;
      return ph ? LVL_HI : LVL_LO;
   endfunction

   // level on a segment pin
   function automatic lvl_t seg_level(input logic lit, input logic ph, input logic half);
      if (lit)  return ph ? LVL_TOP : LVL_GND;
      if (half) return ph ? LVL_GND : LVL_TOP;
      return ph ? LVL_LO : LVL_HI;
   endfunction

endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
   parameter int unsigned RATIO = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick_in,
   output logic tick_out
);
   if (RATIO < 1) begin : g_bad_ratio
      $error("lcd_tick_div: RATIO must be at least 1");
   end

   if (RATIO == 1) begin : g_pass
      logic unused_pass;
      assign unused_pass = ^{clk, rst_n, clr};
      assign tick_out    = tick_in;
   end else begin : g_cnt
      localparam int unsigned CW = $clog2(RATIO);
      logic [CW-1:0] cnt;
      logic          at_end;
      assign at_end = (cnt == CW'(RATIO - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt <= '0;
         else if (clr)     cnt <= '0;
         else if (tick_in) cnt <= at_end ? '0 : cnt + 1'b1;
      end
      assign tick_out = tick_in & at_end;
   end
endmodule

// File: rtl/lcd_clk_prescaler.sv
module lcd_clk_prescaler #(
   parameter int unsigned SLOW_DIV = 32,
   parameter int unsigned FAST_DIV = 8192,
   parameter int unsigned POST_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              src_sel,
   input  logic [POST_W-1:0] div_sel,
   input  logic              slow_tick,
   input  logic              fast_tick,
   output logic              scan_tick
);
   localparam int unsigned PCW = (1 << POST_W) - 1;

   logic slow_in, fast_in, slow_p, fast_p, src_pulse;
   logic [PCW-1:0] pcnt, pmask;

   assign slow_in = run & ~src_sel & slow_tick;
   assign fast_in = run &  src_sel & fast_tick;

   lcd_tick_div #(.RATIO(SLOW_DIV)) u_slow (
      .clk(clk), .rst_n(rst_n), .clr(~run), .tick_in(slow_in), .tick_out(slow_p));
   lcd_tick_div #(.RATIO(FAST_DIV)) u_fast (
      .clk(clk), .rst_n(rst_n), .clr(~run), .tick_in(fast_in), .tick_out(fast_p));

   assign src_pulse = slow_p | fast_p;

   always_comb begin
      pmask = '0;
      for (int b = 0; b < PCW; b++) pmask[b] = (b < int'(div_sel));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pcnt <= '0;
      else if (!run)      pcnt <= '0;
      else if (src_pulse) pcnt <= pcnt + 1'b1;
   end

   assign scan_tick = src_pulse & ((pcnt & pmask) == pmask);
endmodule

// File: rtl/lcd_com_sequencer.sv
module lcd_com_sequencer #(
   parameter int unsigned COM_N         = 4,
   parameter int unsigned TICKS_PER_COM = 1,
   localparam int unsigned CIW          = $clog2(COM_N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           scan_tick,
   input  logic [CIW:0]   n_active,
   output logic [CIW-1:0] com_idx,
   output logic           phase
);
   logic step, last_com;

   if (TICKS_PER_COM <= 1) begin : g_direct
      assign step = scan_tick;
   end else begin : g_dwell
      localparam int unsigned TW = $clog2(TICKS_PER_COM);
      logic [TW-1:0] tcnt;
      logic          tend;
      assign tend = (tcnt == TW'(TICKS_PER_COM - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         tcnt <= '0;
         else if (!run)      tcnt <= '0;
         else if (scan_tick) tcnt <= tend ? '0 : tcnt + 1'b1;
      end
      assign step = scan_tick & tend;
   end

   assign last_com = ({1'b0, com_idx} == (n_active - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         com_idx <= '0;
         phase   <= 1'b0;
      end else if (!run) begin
         com_idx <= '0;
         phase   <= 1'b0;
      end else if (step) begin
         if (last_com) begin
            com_idx <= '0;
            phase   <= ~phase;
         end else begin
            com_idx <= com_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
   parameter int unsigned SEG_N = 40,
   parameter int unsigned COM_N = 4,
   parameter int unsigned AW    = 6,
   localparam int unsigned CIW  = $clog2(COM_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [COM_N-1:0] wdata,
   input  logic [CIW-1:0]   rd_sel,
   output logic [SEG_N-1:0] pix
);
   for (genvar s = 0; s < SEG_N; s++) begin : g_word
      logic [COM_N-1:0] word;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             word <= '0;
         else if (we && (waddr == AW'(s)))       word <= wdata;
      end
      assign pix[s] = word[rd_sel];
   end
endmodule

// File: rtl/lcd_drive_encoder.sv
module lcd_drive_encoder
   import lcd_scan_pkg::*;
#(
   parameter int unsigned SEG_N = 40,
   parameter int unsigned COM_N = 4,
   parameter int unsigned GRP_W = 8,
   parameter int unsigned GRP_N = 5,
   localparam int unsigned CIW  = $clog2(COM_N)
) (
   input  logic               run,
   input  logic               phase,
   input  logic               half_bias,
   input  logic [CIW-1:0]     com_idx,
   input  logic [SEG_N-1:0]   pix,
   input  logic [GRP_N-1:0]   grp_en,
   output logic [2*COM_N-1:0] com_lvl,
   output logic [2*SEG_N-1:0] seg_lvl
);
   for (genvar c = 0; c < COM_N; c++) begin : g_com
      assign com_lvl[2*c +: 2] = run ? com_level(com_idx == CIW'(c), phase, half_bias)
                                     : LVL_GND;
   end

   for (genvar s = 0; s < SEG_N; s++) begin : g_seg
      assign seg_lvl[2*s +: 2] = (run && grp_en[s / GRP_W]) ? seg_level(pix[s], phase, half_bias)
                                                            : LVL_GND;
   end
endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
   import lcd_scan_pkg::*;
#(
   parameter int unsigned GRP_N = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output mode_t            mode,
   output logic [GRP_N-1:0] grp_en
);
   logic unused_wtop;
   assign unused_wtop = wdata[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= '0;
         grp_en <= '0;
      end else if (wr) begin
         if (!addr) mode   <= mode_t'(wdata[6:0]);
         else       grp_en <= wdata[GRP_N-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (!addr) rdata[6:0]       = mode;
      else       rdata[GRP_N-1:0] = grp_en;
   end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
   import lcd_scan_pkg::*;
#(
   parameter int unsigned SEG_N         = 40,
   parameter int unsigned COM_N         = 4,
   parameter int unsigned GRP_W         = 8,
   parameter int unsigned SLOW_DIV      = 32,
   parameter int unsigned FAST_DIV      = 8192,
   parameter int unsigned TICKS_PER_COM = 1,
   parameter int unsigned RAM_AW        = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic               cfg_addr,
   input  logic [7:0]         cfg_wdata,
   output logic [7:0]         cfg_rdata,
   input  logic               slow_tick,
   input  logic               fast_tick,
   input  logic               ram_we,
   input  logic [RAM_AW-1:0]  ram_addr,
   input  logic [COM_N-1:0]   ram_wdata,
   output logic [2*COM_N-1:0] com_lvl,
   output logic [2*SEG_N-1:0] seg_lvl
);
   localparam int unsigned GRP_N = (SEG_N + GRP_W - 1) / GRP_W;
   localparam int unsigned CIW   = $clog2(COM_N);

   if (COM_N != 4) begin : g_bad_com
      $error("lcd_scan_ctrl: the 2-bit commons code needs COM_N == 4");
   end
   if ((1 << RAM_AW) < SEG_N) begin : g_bad_aw
      $error("lcd_scan_ctrl: RAM_AW too narrow for SEG_N");
   end
   if (GRP_N > 7) begin : g_bad_grp
      $error("lcd_scan_ctrl: group register holds at most 7 groups");
   end
   if (TICKS_PER_COM < 1 || SLOW_DIV < 1 || FAST_DIV < 1) begin : g_bad_div
      $error("lcd_scan_ctrl: dividers must be at least 1");
   end

   mode_t            mode_q;
   logic [GRP_N-1:0] grp_en;
   logic             run_en, bias_q, scan_tick, phase;
   logic [CIW-1:0]   com_idx;
   logic [CIW:0]     n_active;
   logic [SEG_N-1:0] pix;

   lcd_cfg_regs #(.GRP_N(GRP_N)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .mode(mode_q), .grp_en(grp_en));

   assign run_en   = mode_q.en & (mode_q.duty != 2'b00);
   assign bias_q   = mode_q.bias;
   assign n_active = {1'b0, mode_q.duty} + 1'b1;

   lcd_clk_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .POST_W(2)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_en), .src_sel(mode_q.src), .div_sel(mode_q.div),
      .slow_tick(slow_tick), .fast_tick(fast_tick), .scan_tick(scan_tick));

   lcd_com_sequencer #(.COM_N(COM_N), .TICKS_PER_COM(TICKS_PER_COM)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run_en), .scan_tick(scan_tick), .n_active(n_active),
      .com_idx(com_idx), .phase(phase));

   lcd_disp_ram #(.SEG_N(SEG_N), .COM_N(COM_N), .AW(RAM_AW)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
      .rd_sel(com_idx), .pix(pix));

   lcd_drive_encoder #(.SEG_N(SEG_N), .COM_N(COM_N), .GRP_W(GRP_W), .GRP_N(GRP_N)) u_enc (
      .run(run_en), .phase(phase), .half_bias(bias_q), .com_idx(com_idx), .pix(pix),
      .grp_en(grp_en), .com_lvl(com_lvl), .seg_lvl(seg_lvl));
endmodule

// File: rtl/lcd_scan_ctrl_chk.sv
module lcd_scan_ctrl_chk #(
   parameter int unsigned SEG_N = 40,
   parameter int unsigned COM_N = 4,
   localparam int unsigned CIW  = $clog2(COM_N)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run_en,
   input logic               bias_q,
   input logic               scan_tick,
   input logic [CIW-1:0]     com_idx,
   input logic               phase,
   input logic [7:0]         cfg_rdata,
   input logic [2*COM_N-1:0] com_lvl,
   input logic [2*SEG_N-1:0] seg_lvl
);
   logic [COM_N-1:0]         sel_vec;
   logic [COM_N+SEG_N-1:0]   has_one;

   for (genvar c = 0; c < COM_N; c++) begin : g_c
      assign sel_vec[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
      assign has_one[c] = (com_lvl[2*c +: 2] == 2'd1);
   end
   for (genvar s = 0; s < SEG_N; s++) begin : g_s
      assign has_one[COM_N+s] = (seg_lvl[2*s +: 2] == 2'd1);
   end

   p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> (com_lvl == '0) && (seg_lvl == '0));

   p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |-> $countones(sel_vec) == 1);

   p_no_third_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && bias_q) |-> (has_one == '0));

   p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && $past(run_en) && (com_idx != $past(com_idx))) |-> $past(scan_tick));

   p_flip_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && $past(run_en) && (phase != $past(phase))) |-> (com_idx == '0));

   p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[7] == 1'b0);
endmodule

bind lcd_scan_ctrl lcd_scan_ctrl_chk #(.SEG_N(SEG_N), .COM_N(COM_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .bias_q(bias_q), .scan_tick(scan_tick),
   .com_idx(com_idx), .phase(phase), .cfg_rdata(cfg_rdata), .com_lvl(com_lvl),
   .seg_lvl(seg_lvl));

// File: tb/lcd_scan_ctrl_bench.sv
module lcd_scan_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SEG_N = 40;
   localparam int COM_N = 4;
   localparam int SLOW  = 32;
   localparam int FAST  = 8192;
   localparam int TPC   = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic               cfg_wr = 0, cfg_addr = 0;
   logic [7:0]         cfg_wdata = '0;
   logic [7:0]         cfg_rdata;
   logic               slow_tick = 0, fast_tick = 0;
   logic               ram_we = 0;
   logic [5:0]         ram_addr = '0;
   logic [3:0]         ram_wdata = '0;
   logic [2*COM_N-1:0] com_lvl;
   logic [2*SEG_N-1:0] seg_lvl;

   lcd_scan_ctrl u_lcd_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .slow_tick(slow_tick), .fast_tick(fast_tick), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .com_lvl(com_lvl), .seg_lvl(seg_lvl));

   int  n_chk = 0, n_bad = 0;
   bit  mon_on = 0, rand_ram = 0, fast_on = 0, done = 0;
   int  tick_pct = 0;

   // reference state, built from the requirements
   logic [1:0] m_duty, m_div;
   logic       m_bias, m_en, m_src;
   logic [4:0] m_grp;
   logic [3:0] m_ram [SEG_N];
   longint     n_ticks;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_src, m_div, m_en, m_bias, m_duty} <= '0;
         m_grp   <= '0;
         n_ticks <= 0;
         for (int s = 0; s < SEG_N; s++) m_ram[s] <= '0;
      end else begin
         if (m_en && m_duty != 0 && (m_src ? fast_tick : slow_tick)) n_ticks <= n_ticks + 1;
         if (cfg_wr) begin
            if (!cfg_addr) begin
               {m_src, m_div, m_en, m_bias, m_duty} <= cfg_wdata[6:0];
               n_ticks <= 0;
            end else m_grp <= cfg_wdata[4:0];
         end
         if (ram_we && ram_addr < SEG_N) m_ram[ram_addr] <= ram_wdata;
      end
   end

   function automatic longint period();
      return longint'(m_src ? FAST : SLOW) * (longint'(1) << m_div) * TPC;
   endfunction

   function automatic logic [7:0] exp_com();
      logic [7:0] v = '0;
      if (m_en && m_duty != 0) begin
         longint d = longint'(m_duty) + 1;
         int cur = int'((n_ticks / period()) % d);
         bit ph  = ((n_ticks / (period() * d)) % 2) != 0;
         for (int i = 0; i < COM_N; i++) begin
            if (i == cur)  v[2*i +: 2] = ph ? 2'd0 : 2'd3;
            else if (m_bias) v[2*i +: 2] = 2'd2;
            else           v[2*i +: 2] = ph ? 2'd2 : 2'd1;
         end
      end
      return v;
   endfunction

   function automatic logic [79:0] exp_seg();
      logic [79:0] v = '0;
      if (m_en && m_duty != 0) begin
         longint d = longint'(m_duty) + 1;
         int cur = int'((n_ticks / period()) % d);
         bit ph  = ((n_ticks / (period() * d)) % 2) != 0;
         for (int s = 0; s < SEG_N; s++) begin
            if (m_grp[s/8]) begin
               if (m_ram[s][cur]) v[2*s +: 2] = ph ? 2'd3 : 2'd0;
               else if (m_bias)   v[2*s +: 2] = ph ? 2'd0 : 2'd3;
               else               v[2*s +: 2] = ph ? 2'd1 : 2'd2;
            end
         end
      end
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [79:0] act, input logic [79:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr <= 1; cfg_addr <= a; cfg_wdata <= d;
      @(negedge clk);
      cfg_wr <= 0;
   endtask

   task automatic wr_ram(input logic [5:0] a, input logic [3:0] d);
      @(negedge clk);
      ram_we <= 1; ram_addr <= a; ram_wdata <= d;
      @(negedge clk);
      ram_we <= 0;
   endtask

   task automatic rd_cfg(input logic a, output logic [7:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   // per-cycle comparison of every pin (R5 R6 R7 R8 R9 R10 R4)
   initial forever begin
      @(negedge clk);
      if (mon_on) begin
         check(com_lvl == exp_com(), "R4 R5 R6 R7", "com_lvl", 80'(com_lvl), 80'(exp_com()));
         check(seg_lvl == exp_seg(), "R8 R9 R10", "seg_lvl", 80'(seg_lvl), exp_seg());
      end
   end

   // tick sources and background display writes
   initial forever begin
      @(negedge clk);
      slow_tick <= ($urandom_range(99) < tick_pct);
      fast_tick <= fast_on ? 1'b1 : ($urandom_range(99) < tick_pct);
      if (rand_ram) begin
         ram_we    <= ($urandom_range(3) == 0);
         ram_addr  <= 6'($urandom_range(47));
         ram_wdata <= 4'($urandom_range(15));
      end
   end

   initial begin
      #(CLK_PERIOD * 180000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      void'($urandom(32'd20240601));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      check(com_lvl == '0, "R1", "com after reset", 80'(com_lvl), 80'(0));
      check(seg_lvl == '0, "R1", "seg after reset", 80'(seg_lvl), 80'(0));
      rd_cfg(0, rd); check(rd == 8'h00, "R1", "mode after reset", 80'(rd), 80'(0));
      rd_cfg(1, rd); check(rd == 8'h00, "R1", "group after reset", 80'(rd), 80'(0));

      // R2: readback with unused bits forced to 0
      wr_cfg(0, 8'hF7);
      rd_cfg(0, rd); check(rd == 8'h77, "R2", "mode readback", 80'(rd), 80'(8'h77));
      wr_cfg(1, 8'hFF);
      rd_cfg(1, rd); check(rd == 8'h1F, "R2", "group readback", 80'(rd), 80'(8'h1F));
      wr_cfg(0, 8'h00);

      // R3: enable with commons code 00, and disable with valid code
      for (int s = 0; s < SEG_N; s++) wr_ram(6'(s), 4'hF);
      tick_pct = 100;
      wr_cfg(0, 8'h08);
      mon_on = 1;
      repeat (300) @(negedge clk);
      check(com_lvl == '0 && seg_lvl == '0, "R3", "code 00 with enable", 80'(com_lvl), 80'(0));
      wr_cfg(0, 8'h07);
      repeat (100) @(negedge clk);
      check(com_lvl == '0 && seg_lvl == '0, "R3", "enable clear", 80'(seg_lvl), 80'(0));
      wr_cfg(0, 8'h00);

      // R5 R6 R7 R8 R9 R10 R11: sweep of commons count, bias and post-divider
      for (int k = 0; k < 12; k++) begin
         logic [1:0] dty, dv;
         logic       bs;
         int         cyc;
         dty = (k < 3) ? 2'(k + 1) : 2'($urandom_range(1, 3));
         bs  = k[0];
         dv  = (k == 0) ? 2'd3 : 2'($urandom_range(2));
         for (int s = 0; s < SEG_N; s++) wr_ram(6'(s), 4'($urandom_range(15)));
         wr_cfg(1, (k == 1) ? 8'h15 : 8'($urandom_range(31)));
         tick_pct = $urandom_range(40, 100);
         wr_cfg(0, {1'b0, 1'b0, dv, 1'b1, bs, dty});
         rand_ram = 1;
         cyc = ((2 * (int'(dty) + 1) + 1) * SLOW * (1 << dv) * 100) / tick_pct;
         repeat (cyc) @(negedge clk);
         rand_ram = 0;
         @(negedge clk);
         ram_we <= 0;
         wr_cfg(0, 8'h00);
      end

      // R9: addresses past the last segment leave the display untouched
      wr_cfg(1, 8'h1F);
      for (int s = 0; s < SEG_N; s++) wr_ram(6'(s), 4'h0);
      wr_ram(6'd40, 4'hF);
      wr_ram(6'd63, 4'hF);
      wr_cfg(0, 8'h0B);
      repeat (400) @(negedge clk);
      // R4: with no ticks the scan holds still
      tick_pct = 0;
      repeat (300) @(negedge clk);
      wr_cfg(0, 8'h00);

      // R4: fast source, slow ticks must not count
      tick_pct = 50;
      fast_on  = 1;
      wr_cfg(0, 8'h4B);
      repeat (FAST * 5 + 20) @(negedge clk);
      fast_on = 0;
      wr_cfg(0, 8'h00);

      mon_on = 0;
      done   = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule